// File: doc/BRIEF.md
# Serial Check-Symbol Predictor for a Randomised Manipulation-Detection Code

This block computes, digit by digit, the redundancy symbol of a nonlinear error-detecting code whose check value depends on both the protected data and fresh random digits. A k-bit result arrives as T digits of R bits, one digit per accepted cycle. Each data digit y comes with its own random digit x from an external random source. For every pair the block forms x*(x*x + y) in GF(2^R) and folds it into an R-bit running XOR. When the T-th term has been folded in, the block publishes the predicted symbol and compares it with a check symbol supplied by the surrounding logic, raising a mismatch flag.

A parameter inserts a register stage between the digit inputs and the field multipliers, which shortens the combinational path at the cost of one extra cycle of latency. A second parameter drops the cubic part of the term, leaving x*y per digit. That form is only sound where the injected data error is known to be nonzero.

Top module: `amd_serial_predictor`

## Requirements
- R1: While rst is high and in the cycle after it, done and error are 0 and f_pred is all zeros.
- R2: With MODE = TERM_CUBIC, f_pred after a frame equals the XOR over its T digits of x*(x*x XOR y). Arithmetic is in GF(2^8), polynomial basis, reduction polynomial 0x11B, and bit n of a port holds the coefficient of z^n.
- R3: A digit is taken only in a cycle with dig_valid high. Cycles with dig_valid low are ignored, whatever y_dig and x_dig carry, so idle cycles may sit anywhere between digits.
- R4: done is a one-cycle pulse. It rises at the clock edge PIPE edges after the edge that captures the T-th digit. With no idle cycles, that is T-1+PIPE edges after the edge that captures the first digit.
- R5: error is high exactly when done is high and f_in, as sampled at the edge that raises done, differs from the predicted symbol. A single flipped bit in f_in or in any y digit (with its x nonzero) sets it.
- R6: After a completion the running sum and digit count restart from zero, so back-to-back frames are independent.
- R7: A start pulse discards the partial frame, including a digit held in the pipeline stage. A digit presented in the same cycle as start is the first digit of the new frame.
- R8: With MODE = TERM_LINEAR, f_pred equals the XOR over the frame of x*y in the same field.
- R9: f_pred keeps its value from one completion to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Abandon the current frame and restart the count |
| dig_valid | input | 1 | y_dig and x_dig carry a digit this cycle |
| y_dig | input | R | Data digit |
| x_dig | input | R | Random digit paired with y_dig |
| f_in | input | R | Check symbol to compare; held until done |
| done | output | 1 | One-cycle pulse: frame complete |
| error | output | 1 | Predicted symbol differs from f_in (valid with done) |
| f_pred | output | R | Predicted check symbol of the last finished frame |

## Verification
Two instances run from the same digit stream: the default one (cubic term, PIPE=1) and a linear one with PIPE=0. Their results are therefore due one edge apart after the edge that takes the last digit. The bench drives inputs on falling edges. On the falling edge right after the last digit's capture edge, it expects done only on the unpipelined instance. One falling edge later it expects done, f_pred and error only on the pipelined instance. Idle gaps between digits do not move these sample points, because latency counts from the last digit, so every check lands in the single cycle in which the pulse is high.

// File: rtl/amd_pkg.sv
package amd_pkg;
  // Selects the per-digit term accumulated by the predictor.
  typedef enum logic {
    TERM_LINEAR = 1'b0,  // x*y only
    TERM_CUBIC  = 1'b1   // x*(x*x ^ y)
  } term_mode_e;
endpackage

// File: rtl/amd_gf_mul.sv
// Combinational GF(2^R) multiplier, polynomial basis, shift-and-add form.
module amd_gf_mul #(
  parameter int unsigned R    = 8,
  parameter logic [R:0]  POLY = 9'h11B
) (
  input  logic [R-1:0] a,
  input  logic [R-1:0] b,
  output logic [R-1:0] p
);
  localparam logic [R-1:0] RED = POLY[R-1:0];

  logic [R-1:0] sh;
  logic [R-1:0] acc;

  always_comb begin
    sh  = a;
    acc = '0;
    for (int i = 0; i < R; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[R-2:0], 1'b0} ^ (sh[R-1] ? RED : '0);
    end
  end

  assign p = acc;
endmodule

// File: rtl/amd_term.sv
// Per-digit term: x*(x*x ^ y) or x*y, picked by MODE.
module amd_term #(
  parameter int unsigned        R    = 8,
  parameter logic [R:0]         POLY = 9'h11B,
  parameter amd_pkg::term_mode_e MODE = amd_pkg::TERM_CUBIC
) (
  input  logic [R-1:0] x,
  input  logic [R-1:0] y,
  output logic [R-1:0] term
);
  logic [R-1:0] opnd;

  generate
    if (MODE == amd_pkg::TERM_CUBIC) begin : g_cubic
      logic [R-1:0] x_sq;
      amd_gf_mul #(.R(R), .POLY(POLY)) sq_i (.a(x), .b(x), .p(x_sq));
      assign opnd = x_sq ^ y;
    end else begin : g_linear
      assign opnd = y;
    end
  endgenerate

  amd_gf_mul #(.R(R), .POLY(POLY)) mul_i (.a(x), .b(opnd), .p(term));
endmodule

// File: rtl/amd_digit_stage.sv
// Optional register between the digit inputs and the multipliers.
module amd_digit_stage #(
  parameter int unsigned R    = 8,
  parameter bit          PIPE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         in_valid,
  input  logic [R-1:0] in_x,
  input  logic [R-1:0] in_y,
  output logic         out_valid,
  output logic [R-1:0] out_x,
  output logic [R-1:0] out_y
);
  generate
    if (PIPE) begin : g_reg
      logic         q_valid;
      logic [R-1:0] q_x;
      logic [R-1:0] q_y;
      always_ff @(posedge clk) begin
        if (rst) begin
          q_valid <= 1'b0;
          q_x     <= '0;
          q_y     <= '0;
        end else begin
          q_valid <= in_valid;
          q_x     <= in_x;
          q_y     <= in_y;
        end
      end
      // A digit still in flight belongs to the abandoned frame.
      assign out_valid = q_valid & ~start;
      assign out_x     = q_x;
      assign out_y     = q_y;
    end else begin : g_pass
      logic unused_start;
      assign unused_start = start;
      assign out_valid = in_valid;
      assign out_x     = in_x;
      assign out_y     = in_y;
    end
  endgenerate
endmodule

// File: rtl/amd_accum.sv
// Running XOR of terms, digit counter, completion and comparison.
module amd_accum #(
  parameter int unsigned R = 8,
  parameter int unsigned T = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         term_valid,
  input  logic [R-1:0] term,
  input  logic [R-1:0] f_in,
  output logic         done,
  output logic         error,
  output logic [R-1:0] f_pred
);
  localparam int unsigned CW = $clog2(T + 1);
  localparam logic [CW-1:0] LAST = CW'(T - 1);

  logic [CW-1:0] cnt;
  logic [R-1:0]  acc;
  logic [R-1:0]  sum;

  assign sum = acc ^ term;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      acc    <= '0;
      done   <= 1'b0;
      error  <= 1'b0;
      f_pred <= '0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      if (start) begin
        acc <= term_valid ? term : '0;
        cnt <= term_valid ? CW'(1) : '0;
      end else if (term_valid) begin
        if (cnt == LAST) begin
          f_pred <= sum;
          done   <= 1'b1;
          error  <= (sum != f_in);
          acc    <= '0;
          cnt    <= '0;
        end else begin
          acc <= sum;
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/amd_serial_predictor.sv
module amd_serial_predictor #(
  parameter int unsigned         R    = 8,
  parameter int unsigned         T    = 4,
  parameter bit                  PIPE = 1'b1,
  parameter logic [R:0]          POLY = 9'h11B,
  parameter amd_pkg::term_mode_e MODE = amd_pkg::TERM_CUBIC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         dig_valid,
  input  logic [R-1:0] y_dig,
  input  logic [R-1:0] x_dig,
  input  logic [R-1:0] f_in,
  output logic         done,
  output logic         error,
  output logic [R-1:0] f_pred
);
  logic         s_valid;
  logic [R-1:0] s_x;
  logic [R-1:0] s_y;
  logic [R-1:0] s_term;

  amd_digit_stage #(.R(R), .PIPE(PIPE)) stage_i (
    .clk(clk), .rst(rst), .start(start),
    .in_valid(dig_valid), .in_x(x_dig), .in_y(y_dig),
    .out_valid(s_valid), .out_x(s_x), .out_y(s_y)
  );

  amd_term #(.R(R), .POLY(POLY), .MODE(MODE)) term_i (
    .x(s_x), .y(s_y), .term(s_term)
  );

  amd_accum #(.R(R), .T(T)) accum_i (
    .clk(clk), .rst(rst), .start(start),
    .term_valid(s_valid), .term(s_term), .f_in(f_in),
    .done(done), .error(error), .f_pred(f_pred)
  );
endmodule

// File: rtl/amd_pred_chk.sv
module amd_pred_chk #(
  parameter int unsigned R = 8,
  parameter int unsigned T = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         done,
  input logic         error,
  input logic [R-1:0] f_pred
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_err_with_done_r5: assert property (@(posedge clk) disable iff (rst)
    error |-> done);

  p_start_kills_done_r7: assert property (@(posedge clk) disable iff (rst)
    start |=> !done);

  p_hold_between_r9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !done) |-> $stable(f_pred));

  generate
    if (T > 1) begin : g_pulse
      p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    end
  endgenerate
endmodule

bind amd_serial_predictor amd_pred_chk #(.R(R), .T(T)) chk_i (
  .clk(clk), .rst(rst), .start(start),
  .done(done), .error(error), .f_pred(f_pred)
);

// File: tb/amd_serial_predictor_tb_top.sv
module amd_serial_predictor_tb_top;
  localparam int R = 8;
  localparam int T = 4;

  logic clk = 1'b0;
  logic rst, start, dv;
  logic [R-1:0] yd, xd, fin_c, fin_l;
  logic done_c, err_c, done_l, err_l;
  logic [R-1:0] fp_c, fp_l;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  amd_serial_predictor #(.R(R), .T(T), .PIPE(1'b1), .MODE(amd_pkg::TERM_CUBIC)) dut_i (
    .clk(clk), .rst(rst), .start(start), .dig_valid(dv), .y_dig(yd), .x_dig(xd),
    .f_in(fin_c), .done(done_c), .error(err_c), .f_pred(fp_c));

  amd_serial_predictor #(.R(R), .T(T), .PIPE(1'b0), .MODE(amd_pkg::TERM_LINEAR)) dut_lin_i (
    .clk(clk), .rst(rst), .start(start), .dig_valid(dv), .y_dig(yd), .x_dig(xd),
    .f_in(fin_l), .done(done_l), .error(err_l), .f_pred(fp_l));

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ a;
      a = {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] f_cub(input logic [7:0] ys [4], input logic [7:0] xs [4]);
    logic [7:0] s = 8'h00;
    for (int i = 0; i < 4; i++) s = s ^ gm(xs[i], gm(xs[i], xs[i]) ^ ys[i]);
    return s;
  endfunction

  function automatic logic [7:0] f_lin(input logic [7:0] ys [4], input logic [7:0] xs [4]);
    logic [7:0] s = 8'h00;
    for (int i = 0; i < 4; i++) s = s ^ gm(xs[i], ys[i]);
    return s;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Drive one frame; ymask flips bits in y digit yidx; fmask flips f_in of the cubic instance.
  task automatic frame(input string req, input logic [7:0] ys [4], input logic [7:0] xs [4],
                       input int gapmax, input bit start_first,
                       input int yidx, input logic [7:0] ymask, input logic [7:0] fmask);
    logic [7:0] yv [4];
    logic [7:0] pc, pl;
    for (int i = 0; i < 4; i++) yv[i] = (i == yidx) ? (ys[i] ^ ymask) : ys[i];
    pc = f_cub(yv, xs);
    pl = f_lin(yv, xs);
    fin_c = f_cub(ys, xs) ^ fmask;
    fin_l = f_lin(ys, xs);
    for (int i = 0; i < 4; i++) begin
      int g = (gapmax > 0) ? int'($urandom_range(gapmax)) : 0;
      for (int k = 0; k < g; k++) begin
        dv = 1'b0; yd = 8'($urandom); xd = 8'($urandom);
        @(negedge clk);
      end
      dv = 1'b1; yd = yv[i]; xd = xs[i];
      start = (i == 0) && start_first;
      @(negedge clk);
      start = 1'b0;
    end
    dv = 1'b0; yd = 8'($urandom); xd = 8'($urandom);
    // Falling edge after the last capture edge: only the unpipelined instance is done.
    chk("R4", "lin done", 32'(done_l), 32'd1);
    chk("R8", "lin f_pred", 32'(fp_l), 32'(pl));
    chk("R5", "lin error", 32'(err_l), 32'(fin_l != pl));
    chk("R4", "pipe done early", 32'(done_c), 32'd0);
    @(negedge clk);
    chk("R4", "pipe done", 32'(done_c), 32'd1);
    chk(req, "pipe f_pred", 32'(fp_c), 32'(pc));
    chk("R5", "pipe error", 32'(err_c), 32'(fin_c != pc));
    chk("R4", "lin done pulse", 32'(done_l), 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [7:0] ys [4];
    logic [7:0] xs [4];
    logic [7:0] held;
    void'($urandom(32'd1234));
    rst = 1'b1; start = 1'b0; dv = 1'b0; yd = '0; xd = '0; fin_c = '0; fin_l = '0;
    repeat (4) @(negedge clk);
    chk("R1", "done in reset", 32'(done_c), 32'd0);
    chk("R1", "error in reset", 32'(err_c), 32'd0);
    chk("R1", "f_pred in reset", 32'(fp_c), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "done after reset", 32'(done_c | done_l), 32'd0);
    chk("R1", "f_pred after reset", 32'(fp_c | fp_l), 32'd0);

    // Directed: all zero, all ones, x=1.
    ys = '{8'h00, 8'h00, 8'h00, 8'h00}; xs = '{8'h00, 8'h00, 8'h00, 8'h00};
    frame("R2", ys, xs, 0, 1'b0, 0, 8'h00, 8'h00);
    ys = '{8'hFF, 8'hFF, 8'hFF, 8'hFF}; xs = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
    frame("R2", ys, xs, 0, 1'b0, 0, 8'h00, 8'h00);
    ys = '{8'h57, 8'h83, 8'h01, 8'h80}; xs = '{8'h01, 8'h02, 8'h03, 8'hCA};
    frame("R6", ys, xs, 0, 1'b0, 0, 8'h00, 8'h00);

    // R9: result held while idle.
    held = fp_c;
    repeat (3) @(negedge clk);
    chk("R9", "f_pred held", 32'(fp_c), 32'(held));
    chk("R9", "no done while idle", 32'(done_c), 32'd0);

    // Random frames, back to back (R6) and with idle gaps (R3).
    for (int n = 0; n < 30; n++) begin
      for (int i = 0; i < 4; i++) begin ys[i] = 8'($urandom); xs[i] = 8'($urandom); end
      frame((n % 2 == 0) ? "R3" : "R6", ys, xs, (n % 2 == 0) ? 3 : 0, 1'b0, 0, 8'h00, 8'h00);
    end

    // R5: single-bit flips in f_in and in each y digit.
    for (int b = 0; b < 8; b++) begin
      for (int i = 0; i < 4; i++) begin ys[i] = 8'($urandom); xs[i] = 8'($urandom) | 8'h01; end
      frame("R5", ys, xs, 1, 1'b0, 0, 8'h00, 8'(1 << b));
    end
    for (int d = 0; d < 4; d++) begin
      for (int i = 0; i < 4; i++) begin ys[i] = 8'($urandom); xs[i] = 8'($urandom) | 8'h01; end
      frame("R5", ys, xs, 1, 1'b0, d, 8'(1 << d), 8'h00);
    end

    // R7: two digits of a frame, then start with the first digit of a new one.
    for (int i = 0; i < 2; i++) begin
      dv = 1'b1; yd = 8'($urandom); xd = 8'($urandom) | 8'h01;
      @(negedge clk);
    end
    ys = '{8'h12, 8'h34, 8'h56, 8'h78}; xs = '{8'h9A, 8'hBC, 8'hDE, 8'hF1};
    frame("R7", ys, xs, 0, 1'b1, 0, 8'h00, 8'h00);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule